// File: doc/BRIEF.md
# ADC Conversion Sequencer with Hardware Averaging

This block is the digital control core of a successive-approximation converter. Software writes a small register set to pick a channel, an output resolution, a sample-window extension and an averaging depth. A write to the channel register with a live channel number starts a conversion. The sequencer spends a fixed start overhead and then one sample window per averaged sample. At the last cycle of each window it strobes an abstract converter data port. It sums the samples, divides by the sample count with a shift, masks the result to the chosen width and stores it. It then raises a completion flag and, if enabled, an interrupt.

One conversion-clock cycle equals one cycle of `clk_i`. Conversions run single-shot or back-to-back. A calibration request runs a fixed-length sequence that ends like a conversion. If a channel write interrupts it, the request reports failure. The analog converter itself is outside the block and is represented by `samp_data_i`, which is sampled while `samp_strobe_o` is high.

Register addresses on `addr_i`: 0 channel control, 1 status, 2 configuration, 3 general control, 4 result.

Top module: `sar_seq`

## Requirements
- R1: After reset the status, result, general-control readback, `irq_o` and `samp_strobe_o` are all zero.
- R2: The completion flag (status bit 0) reads 0 one cycle before, and 1 exactly at, 6 + N×(25 + L) cycles after the clock edge that accepts a channel write, where N is the sample count and L the window extension.
- R3: L is set by configuration bit 4 and bits 9:8. With bit 4 clear, sub-select 0,1,2,3 gives L = 3,5,7,9. With bit 4 set, it gives L = 13,17,21,25.
- R4: General-control bit 5 enables averaging. With it set, configuration bits 15:14 = 0,1,2,3 take N = 4,8,16,32 strobed samples. With it clear, exactly one sample is taken.
- R5: The stored result (address 4, bits 11:0) is the sum of the N samples shifted right by log2(N), masked by configuration bits 3:2: 00 keeps 8 bits, 01 keeps 10 bits, 10 keeps 12 bits.
- R6: Channel-control bits 4:0 drive `ch_sel_o`. Bit 7 enables the interrupt: `irq_o` is high while the completion flag is set and that bit is 1.
- R7: Writing channel value 0x1F aborts a running conversion. No further strobe and no completion follow.
- R8: A read of the result register clears the completion flag and drops `irq_o`.
- R9: With general-control bit 6 set, a new conversion on the same channel starts at each completion. When the bit is cleared, the conversion in flight completes and no further one starts.
- R10: Configuration bit 16 allows overwrite. With it clear, a result finishing while the completion flag is still set is discarded. With it set, the result replaces the unread one.
- R11: Writing general-control bit 7 starts calibration. The completion flag sets 41 cycles after the accepting edge (calibration length 40 plus one cycle to begin). Bit 7 then reads back 0 and status bit 1 (failure) reads 0.
- R12: A channel write during calibration ends it. Status bit 1 becomes 1, general-control bit 7 reads 0, and the written conversion runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects on result read) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| ch_sel_o | output | 5 | Channel routed to the converter |
| samp_strobe_o | output | 1 | High in the last cycle of each sample window |
| samp_data_i | input | 12 | Converter sample, captured while strobe is high |
| irq_o | output | 1 | Completion interrupt |

## Verification
For every conversion, the bench records the edge that accepted the channel write. It computes 6 + N×(25 + L) from the programmed fields. It reads the status one cycle early to expect 0, then on the due cycle to expect 1. The strobe count and the averaged result are also checked on that due cycle.

For continuous mode, completions fall on whole multiples of that period from the first write edge. Calibration completes 41 cycles after its write. All samples are taken mid-cycle, counted from a free-running edge counter, and never from a fixed delay after a task call.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam logic [2:0] ADDR_CHAN = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_CFG  = 3'd2;
  localparam logic [2:0] ADDR_GCTL = 3'd3;
  localparam logic [2:0] ADDR_RES  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OVH  = 2'd1,
    ST_SAMP = 2'd2,
    ST_CAL  = 2'd3
  } seq_state_e;

  // window extension: short set 3..9 step 2, long set 13..25 step 4
  function automatic logic [4:0] extra_cycles(input logic lng, input logic [1:0] sel);
    return lng ? 5'd13 + {1'b0, sel, 2'b00} : 5'd3 + {2'b00, sel, 1'b0};
  endfunction

  function automatic logic [2:0] avg_shift(input logic en, input logic [1:0] sel);
    return en ? {1'b0, sel} + 3'd2 : 3'd0;
  endfunction
endpackage

// File: rtl/sar_seq_regs.sv
module sar_seq_regs
  import sar_seq_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [DATA_W-1:0] result_i,
  input  logic              conv_fin_i,
  input  logic              cal_done_i,
  input  logic              cal_abort_i,
  output logic [CH_W-1:0]   chan_o,
  output logic              start_o,
  output logic              stop_o,
  output logic [1:0]        res_mode_o,
  output logic              lng_o,
  output logic [1:0]        lsel_o,
  output logic [1:0]        asel_o,
  output logic              ovwr_o,
  output logic              avg_en_o,
  output logic              cont_o,
  output logic              cal_req_o,
  output logic              done_o,
  output logic              irq_o
);
  localparam logic [CH_W-1:0] CH_OFF = '1;

  logic wr_chan, wr_cfg, wr_gctl, rd_res;
  logic ien_q, cal_q, calfail_q, done_q;
  logic unused_wdata;

  assign wr_chan = wr_en_i && (addr_i == ADDR_CHAN);
  assign wr_cfg  = wr_en_i && (addr_i == ADDR_CFG);
  assign wr_gctl = wr_en_i && (addr_i == ADDR_GCTL);
  assign rd_res  = rd_en_i && (addr_i == ADDR_RES);
  assign start_o = wr_chan && (wdata_i[CH_W-1:0] != CH_OFF);
  assign stop_o  = wr_chan && (wdata_i[CH_W-1:0] == CH_OFF);
  assign unused_wdata = ^{wdata_i[31:17], wdata_i[13:10]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_o     <= CH_OFF;
      ien_q      <= 1'b0;
      res_mode_o <= 2'b00;
      lng_o      <= 1'b0;
      lsel_o     <= 2'b00;
      asel_o     <= 2'b00;
      ovwr_o     <= 1'b0;
      avg_en_o   <= 1'b0;
      cont_o     <= 1'b0;
      cal_q      <= 1'b0;
      calfail_q  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      if (wr_chan) begin
        chan_o <= wdata_i[CH_W-1:0];
        ien_q  <= wdata_i[7];
      end
      if (wr_cfg) begin
        res_mode_o <= wdata_i[3:2];
        lng_o      <= wdata_i[4];
        lsel_o     <= wdata_i[9:8];
        asel_o     <= wdata_i[15:14];
        ovwr_o     <= wdata_i[16];
      end
      if (wr_gctl) begin
        avg_en_o <= wdata_i[5];
        cont_o   <= wdata_i[6];
      end
      // calibrate bit: set by software, cleared only by the sequence
      if (cal_done_i || cal_abort_i) cal_q <= 1'b0;
      else if (wr_gctl && wdata_i[7]) cal_q <= 1'b1;
      if (cal_abort_i) calfail_q <= 1'b1;
      else if (wr_gctl && wdata_i[7]) calfail_q <= 1'b0;
      if (conv_fin_i || cal_done_i) done_q <= 1'b1;
      else if (rd_res) done_q <= 1'b0;
    end
  end

  assign cal_req_o = cal_q;
  assign done_o    = done_q;
  assign irq_o     = done_q & ien_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CHAN: begin
        rdata_o[CH_W-1:0] = chan_o;
        rdata_o[7]        = ien_q;
      end
      ADDR_STAT: rdata_o[1:0] = {calfail_q, done_q};
      ADDR_CFG: begin
        rdata_o[3:2]   = res_mode_o;
        rdata_o[4]     = lng_o;
        rdata_o[9:8]   = lsel_o;
        rdata_o[15:14] = asel_o;
        rdata_o[16]    = ovwr_o;
      end
      ADDR_GCTL: rdata_o[7:5] = {cal_q, cont_o, avg_en_o};
      ADDR_RES:  rdata_o[DATA_W-1:0] = result_i;
      default:   rdata_o = '0;
    endcase
  end

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_res && !conv_fin_i && !cal_done_i) |=> !done_q);
  a_r11_cal_done_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_i |=> (done_q && !cal_q && !calfail_q));
  a_r12_abort_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_abort_i |=> (calfail_q && !cal_q));
endmodule

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
  import sar_seq_pkg::*;
#(
  parameter int OVH_CYC  = 6,
  parameter int BASE_CYC = 25,
  parameter int CAL_CYC  = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       cal_req_i,
  input  logic       cont_i,
  input  logic [4:0] extra_i,
  input  logic [2:0] shift_i,
  output logic       strobe_o,
  output logic       first_o,
  output logic       conv_fin_o,
  output logic       cal_done_o,
  output logic       cal_abort_o
);
  localparam int MAXC  = (CAL_CYC > BASE_CYC + 25) ? CAL_CYC : BASE_CYC + 25;
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, samp_len;
  logic [5:0]       smp_q, n_last;
  logic             hold;

  assign samp_len    = CNT_W'(BASE_CYC) + CNT_W'(extra_i);
  assign n_last      = 6'((7'd1 << shift_i) - 7'd1);
  assign hold        = start_i | stop_i;
  assign strobe_o    = (state_q == ST_SAMP) && (cnt_q == samp_len - CNT_W'(1)) && !hold;
  assign first_o     = (smp_q == 6'd0);
  assign conv_fin_o  = strobe_o && (smp_q == n_last);
  assign cal_done_o  = (state_q == ST_CAL) && (cnt_q == CNT_W'(CAL_CYC - 1)) && !hold;
  assign cal_abort_o = (state_q == ST_CAL) && hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      smp_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_OVH;
      cnt_q   <= '0;
      smp_q   <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cal_req_i) begin
          state_q <= ST_CAL;
          cnt_q   <= '0;
        end
        ST_OVH: begin
          if (cnt_q == CNT_W'(OVH_CYC - 1)) begin
            state_q <= ST_SAMP;
            cnt_q   <= '0;
            smp_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_SAMP: begin
          if (strobe_o) begin
            cnt_q <= '0;
            if (conv_fin_o) begin
              state_q <= cont_i ? ST_OVH : ST_IDLE;
              smp_q   <= '0;
            end else smp_q <= smp_q + 6'd1;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_CAL: begin
          if (cal_done_o) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_overhead_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAMP && $past(state_q) == ST_OVH) |-> ($past(cnt_q) == CNT_W'(OVH_CYC - 1)));
  a_r7_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (state_q == ST_IDLE && !strobe_o));
  a_r9_cont_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_fin_o && cont_i) |=> (state_q == ST_OVH && cnt_q == '0));
endmodule

// File: rtl/sar_seq_accum.sv
module sar_seq_accum #(
  parameter int DATA_W = 12,
  parameter int ACC_W  = DATA_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              first_i,
  input  logic              fin_i,
  input  logic              keep_i,
  input  logic [2:0]        shift_i,
  input  logic [1:0]        res_mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] result_o
);
  logic [ACC_W-1:0]  acc_q, acc_nxt, avg;
  logic [DATA_W-1:0] mask;
  logic              unused_avg;

  assign acc_nxt    = (first_i ? '0 : acc_q) + ACC_W'(data_i);
  assign avg        = acc_nxt >> shift_i;
  assign unused_avg = ^avg[ACC_W-1:DATA_W];

  always_comb begin
    case (res_mode_i)
      2'b00:   mask = DATA_W'({8{1'b1}});
      2'b01:   mask = DATA_W'({10{1'b1}});
      default: mask = DATA_W'({12{1'b1}});
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      result_o <= '0;
    end else begin
      if (strobe_i) acc_q <= acc_nxt;
      if (fin_i && !keep_i) result_o <= avg[DATA_W-1:0] & mask;
    end
  end

  a_r10_keep_unread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && keep_i) |=> $stable(result_o));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int CH_W     = 5,
  parameter int DATA_W   = 12,
  parameter int OVH_CYC  = 6,
  parameter int BASE_CYC = 25,
  parameter int CAL_CYC  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [CH_W-1:0]   ch_sel_o,
  output logic              samp_strobe_o,
  input  logic [DATA_W-1:0] samp_data_i,
  output logic              irq_o
);
  localparam int ACC_W = DATA_W + 5;

  logic              start, stop, lng, ovwr, avg_en, cont, cal_req, done;
  logic [1:0]        res_mode, lsel, asel;
  logic              first, conv_fin, cal_done, cal_abort;
  logic [DATA_W-1:0] result;
  logic [2:0]        shift;
  logic [4:0]        extra;

  assign shift = avg_shift(avg_en, asel);
  assign extra = extra_cycles(lng, lsel);

  sar_seq_regs #(.CH_W(CH_W), .DATA_W(DATA_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .result_i(result), .conv_fin_i(conv_fin), .cal_done_i(cal_done),
    .cal_abort_i(cal_abort), .chan_o(ch_sel_o), .start_o(start), .stop_o(stop),
    .res_mode_o(res_mode), .lng_o(lng), .lsel_o(lsel), .asel_o(asel),
    .ovwr_o(ovwr), .avg_en_o(avg_en), .cont_o(cont), .cal_req_o(cal_req),
    .done_o(done), .irq_o
  );

  sar_seq_timer #(.OVH_CYC(OVH_CYC), .BASE_CYC(BASE_CYC), .CAL_CYC(CAL_CYC)) i_timer (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop), .cal_req_i(cal_req),
    .cont_i(cont), .extra_i(extra), .shift_i(shift), .strobe_o(samp_strobe_o),
    .first_o(first), .conv_fin_o(conv_fin), .cal_done_o(cal_done),
    .cal_abort_o(cal_abort)
  );

  sar_seq_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_accum (
    .clk_i, .rst_ni, .strobe_i(samp_strobe_o), .first_i(first), .fin_i(conv_fin),
    .keep_i(done && !ovwr), .shift_i(shift), .res_mode_i(res_mode),
    .data_i(samp_data_i), .result_o(result)
  );
endmodule

// File: tb/test_sar_seq.sv
module test_sar_seq;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0, rdata;
  logic [4:0]  ch_sel;
  logic        strobe, irq;
  logic [11:0] samp_data;
  int n_chk = 0, n_fail = 0, cyc = 0, kstr = 0;
  bit fin = 1'b0;

  sar_seq i_sar_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ch_sel_o(ch_sel), .samp_strobe_o(strobe),
    .samp_data_i(samp_data), .irq_o(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (strobe) kstr <= kstr + 1;
  end

  function automatic logic [11:0] smp(input int k);
    return 12'(k * 337 + 91);
  endfunction
  assign samp_data = smp(kstr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata; rd_en = 1'b1;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) begin @(posedge clk); #1; end
    #4;
  endtask

  function automatic int mask_of(input int res);
    return (res == 0) ? 'hFF : (res == 1) ? 'h3FF : 'hFFF;
  endfunction

  function automatic int exp_avg(input int k0, input int sh, input int res);
    int s = 0;
    for (int i = 0; i < (1 << sh); i++) s += smp(k0 + i);
    return (s >> sh) & mask_of(res);
  endfunction

  // one conversion with full timing, count, result and flag checks
  task automatic run_conv(input int ch, input int lng, input int lsel, input int a, input int res, input int ien);
    logic [31:0] d;
    int L, sh, T, k0, w, cfgw;
    L  = lng ? 13 + 4 * lsel : 3 + 2 * lsel;
    sh = (a == 0) ? 0 : a + 1;
    T  = 6 + (1 << sh) * (25 + L);
    cfgw = (1 << 16) | (((a == 0) ? 0 : a - 1) << 14) | (lsel << 8) | (lng << 4) | (res << 2);
    wr(3'd2, cfgw);
    wr(3'd3, (a == 0) ? 0 : 32'h20);
    k0 = kstr;
    wr(3'd0, (ien << 7) | ch);
    w = cyc;
    wait_to(w + T - 1);
    peek(3'd1, d); chk("R2 R3 not yet done", d[0], 1'b0);
    chk("R6 channel out", ch_sel, ch);
    wait_to(w + T);
    peek(3'd1, d); chk("R2 R3 done on time", d[0], 1'b1);
    chk("R6 irq", irq, ien);
    chk("R4 sample count", kstr - k0, 1 << sh);
    rd(3'd4, d); chk("R5 averaged result", d, exp_avg(k0, sh, res));
    peek(3'd1, d); chk("R8 done cleared", d[0], 1'b0);
    chk("R8 irq cleared", irq, 1'b0);
  endtask

  initial begin : main
    logic [31:0] d;
    int w, k0, T;
    #35 rst_n = 1'b1;
    @(posedge clk); #5;
    peek(3'd1, d); chk("R1 status", d, 0);
    peek(3'd4, d); chk("R1 result", d, 0);
    peek(3'd3, d); chk("R1 gctl", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 strobe", strobe, 0);

    // sweep every window extension against every averaging depth
    for (int lng = 0; lng < 2; lng++)
      for (int ls = 0; ls < 4; ls++)
        for (int a = 0; a < 5; a++)
          run_conv((lng * 4 + ls + a) % 15, lng, ls, a, (lng * 4 + ls + a) % 3, a % 2);

    // R7: abort with channel 0x1F
    wr(3'd2, 32'h0000_0318 | 32'h8);
    wr(3'd3, 0);
    k0 = kstr;
    wr(3'd0, 32'h82);
    w = cyc;
    wait_to(w + 20);
    wr(3'd0, 32'h1F);
    wait_to(w + 120);
    peek(3'd1, d); chk("R7 no completion after stop", d[0], 1'b0);
    chk("R7 no strobe after stop", kstr - k0, 0);
    chk("R7 irq low", irq, 1'b0);

    // R9: continuous, L=3, one sample, 12-bit
    T = 34;
    wr(3'd2, 32'h1_0008);
    wr(3'd3, 32'h40);
    k0 = kstr;
    wr(3'd0, 4);
    w = cyc;
    wait_to(w + T);
    rd(3'd4, d); chk("R9 first result", d, smp(k0));
    wait_to(w + 2 * T - 1);
    peek(3'd1, d); chk("R9 second not early", d[0], 1'b0);
    wait_to(w + 2 * T);
    peek(3'd1, d); chk("R9 second on time", d[0], 1'b1);
    rd(3'd4, d); chk("R9 second result", d, smp(k0 + 1));
    wr(3'd3, 0);
    wait_to(w + 3 * T);
    peek(3'd1, d); chk("R9 in-flight completes", d[0], 1'b1);
    rd(3'd4, d); chk("R9 third result", d, smp(k0 + 2));
    wait_to(w + 5 * T);
    peek(3'd1, d); chk("R9 stopped", d[0], 1'b0);
    chk("R9 sample total", kstr - k0, 3);

    // R10: overwrite disabled keeps first, enabled takes second
    for (int ov = 0; ov < 2; ov++) begin
      wr(3'd2, (ov << 16) | 32'h8);
      k0 = kstr;
      wr(3'd0, 1);
      w = cyc;
      wait_to(w + T);
      wr(3'd0, 1);
      w = cyc;
      wait_to(w + T);
      rd(3'd4, d); chk("R10 overwrite policy", d, ov ? smp(k0 + 1) : smp(k0));
    end

    // R12: channel write during calibration
    wr(3'd2, 32'h1_0008);
    wr(3'd0, 32'h1F);
    wr(3'd3, 32'h80);
    wait_to(cyc + 5);
    k0 = kstr;
    wr(3'd0, 3);
    w = cyc;
    rd(3'd3, d); chk("R12 cal bit cleared", d[7], 1'b0);
    peek(3'd1, d); chk("R12 fail flag", d[1], 1'b1);
    wait_to(w + T);
    peek(3'd1, d); chk("R12 conversion runs", d[0], 1'b1);
    rd(3'd4, d); chk("R12 conversion result", d, smp(k0));

    // R11: full calibration
    wr(3'd0, 32'h9F);
    wr(3'd3, 32'h80);
    w = cyc;
    wait_to(w + 40);
    peek(3'd1, d); chk("R11 not yet done", d, 0);
    wait_to(w + 41);
    peek(3'd1, d); chk("R11 done and pass", d, 1);
    chk("R11 irq", irq, 1'b1);
    rd(3'd3, d); chk("R11 cal bit self-clears", d, 0);
    rd(3'd4, d);
    peek(3'd1, d); chk("R8 cleared after cal", d[0], 1'b0);

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule